// File: doc/BRIEF.md
# Burst Write Target with Byte-Lane Memory

This block is the receiving end of the write path of a valid/ready memory-mapped bus. It accepts one write address, together with a beat count, a transfer size and a burst type. It then takes the data beats and stores them in a small internal memory. Each beat writes only the byte lanes whose strobe bit is set. When the beat flagged as last has been accepted, the block returns a single response for the whole burst.

Only one burst is in flight at a time. The address channel closes at its handshake and reopens only after the response handshake. The block supports incrementing bursts only. Other burst types, and sizes wider than the data bus, still drain their data beats, but they write nothing and return an error. A beat count that disagrees with the position of the last flag also produces an error response.

A narrow word-wide read port lets a neighbouring read path observe the stored contents.

Top module: `wr_burst_target`

## Requirements
- R1: After reset `aw_ready` is 1, `w_ready` is 0 and `b_valid` is 0, and every memory byte reads 0. `aw_ready` is high while idle, whether or not `aw_valid` is high. The address, length (`aw_len`, beats = `aw_len`+1), size (bytes = 2^`aw_size`) and burst type are captured on the cycle where `aw_valid` and `aw_ready` are both high.
- R2: `w_ready` is 0 until the cycle after the address handshake, and it is 1 from then until the last-flagged beat is accepted. Data presented while idle is ignored: it writes nothing and produces no response.
- R3: An accepted beat writes byte lane i of `w_data` (bits 8i+7..8i) into memory word (current address / 4) mod 16, at byte i, only where `w_strb[i]` is 1. Lanes whose strobe bit is 0 keep their old contents.
- R4: After each beat, the current address becomes the address rounded down to a multiple of 2^size, plus 2^size. Only the first beat of a burst can therefore be unaligned. The address wraps modulo 256, and memory words wrap modulo 16.
- R5: Exactly one response is issued per burst. It starts on the cycle after the last-flagged beat is accepted, and never earlier. `b_valid` and `b_resp` hold steady until `b_ready` is seen.
- R6: A burst of incrementing type (`aw_burst` = 2'b01) with size at most 2, whose last flag is on beat `aw_len`+1, returns OKAY (`b_resp` = 2'b00).
- R7: If the last flag arrives before beat `aw_len`+1, the burst ends at that beat. The beats accepted so far are written, and the response is SLVERR (2'b10).
- R8: If the last flag arrives after beat `aw_len`+1, the beats beyond the count are accepted but not written. The response is SLVERR (2'b10).
- R9: `aw_ready` is 0 from the cycle after the address handshake until the cycle after the response handshake, and it is 1 again after that.
- R10: A burst type other than 2'b01, or a size above 2, still accepts beats up to the last flag. It writes nothing and returns SLVERR (2'b10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_addr | input | 8 | Burst start byte address |
| aw_len | input | 8 | Beats minus one |
| aw_size | input | 3 | Log2 of bytes per beat |
| aw_burst | input | 2 | Burst type, 2'b01 incrementing |
| aw_valid | input | 1 | Address valid |
| aw_ready | output | 1 | Address ready |
| w_data | input | 32 | Beat data |
| w_strb | input | 4 | Byte-lane write enables |
| w_last | input | 1 | Marks the final beat |
| w_valid | input | 1 | Data valid |
| w_ready | output | 1 | Data ready |
| b_resp | output | 2 | Burst response, 2'b00 OKAY, 2'b10 SLVERR |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| mem_rd_word | input | 4 | Word index for the observation port |
| mem_rd_data | output | 32 | Stored word at `mem_rd_word` |

## Verification
The storage path is tried with four kinds of burst:
- Single-beat and multi-beat word bursts with aligned starts, which show that beats land in consecutive words.
- Unaligned word and halfword bursts, which tell apart correct realignment after the first beat from a plain add of the transfer size.
- Byte-sized bursts, which separate strobe-driven lane selection from full-word writes.
- A burst that runs past the top of memory, which exposes wrap handling.

The error path is tried separately:
- Early and late last flags, which show that the beat count and the last flag are compared, and that surplus beats are dropped.
- Unsupported burst types and sizes, which show that the write enable is suppressed while the data is still drained.

Random stalls on every valid and ready confirm that each result is independent of handshake timing.

// File: rtl/wr_burst_pkg.sv
package wr_burst_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_RESP = 2'd2
    } phase_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] BURST_INCR  = 2'b01;

endpackage

// File: rtl/wr_burst_step.sv
module wr_burst_step #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] mask;

    always_comb begin
        step     = {{(ADDR_W-1){1'b0}}, 1'b1} << size;
        mask     = step - {{(ADDR_W-1){1'b0}}, 1'b1};
        nxt_addr = (cur_addr & ~mask) + step;
    end
endmodule

// File: rtl/wr_burst_mem.sv
module wr_burst_mem #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 16,
    localparam int STRB_W = DATA_W / 8,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar g = 0; g < STRB_W; g++) begin : g_lane
        logic [7:0] lane_q [WORDS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++) lane_q[i] <= '0;
            end else if (we && wr_strb[g]) begin
                lane_q[wr_word] <= wr_data[8*g +: 8];
            end
        end

        assign rd_data[8*g +: 8] = lane_q[rd_word];
    end
endmodule

// File: rtl/wr_burst_ctrl.sv
module wr_burst_ctrl
    import wr_burst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8,
    parameter int LANE_W = 2,
    parameter int WIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [2:0]        aw_size,
    input  logic [1:0]        aw_burst,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic              w_valid,
    input  logic              w_last,
    output logic              w_ready,
    output logic [1:0]        b_resp,
    output logic              b_valid,
    input  logic              b_ready,
    input  logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [2:0]        cur_size,
    output logic [WIDX_W-1:0] wr_word,
    output logic              wr_en
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  beat;
        logic [2:0]        size;
        logic              bad;
        logic              over;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        aw_ready = (st_q.ph == PH_IDLE);
        w_ready  = (st_q.ph == PH_DATA);
        b_valid  = (st_q.ph == PH_RESP);
        b_resp   = st_q.bad ? RESP_SLVERR : RESP_OKAY;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (aw_valid) begin
                    st_d.ph   = PH_DATA;
                    st_d.addr = aw_addr;
                    st_d.len  = aw_len;
                    st_d.size = aw_size;
                    st_d.beat = '0;
                    st_d.over = 1'b0;
                    st_d.bad  = (aw_burst != BURST_INCR) || (aw_size > 3'(LANE_W));
                end
            end
            PH_DATA: begin
                if (w_valid) begin
                    wr_en     = !st_q.bad && !st_q.over;
                    st_d.addr = nxt_addr;
                    st_d.beat = st_q.beat + 1'b1;
                    if (st_q.beat == st_q.len) st_d.over = 1'b1;
                    if (w_last) begin
                        st_d.ph = PH_RESP;
                        if (st_q.over || (st_q.beat != st_q.len)) st_d.bad = 1'b1;
                    end
                end
            end
            PH_RESP: begin
                if (b_ready) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr = st_q.addr;
    assign cur_size = st_q.size;
    assign wr_word  = st_q.addr[LANE_W +: WIDX_W];
endmodule

// File: rtl/wr_burst_target.sv
module wr_burst_target #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 8,
    parameter int MEM_BYTES = 64,
    localparam int STRB_W   = DATA_W / 8,
    localparam int LANE_W   = $clog2(STRB_W),
    localparam int WORDS    = MEM_BYTES / STRB_W,
    localparam int WIDX_W   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [2:0]        aw_size,
    input  logic [1:0]        aw_burst,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [STRB_W-1:0] w_strb,
    input  logic              w_last,
    input  logic              w_valid,
    output logic              w_ready,
    output logic [1:0]        b_resp,
    output logic              b_valid,
    input  logic              b_ready,
    input  logic [WIDX_W-1:0] mem_rd_word,
    output logic [DATA_W-1:0] mem_rd_data
);
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [2:0]        cur_size;
    logic [WIDX_W-1:0] wr_word;
    logic              wr_en;

    wr_burst_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .LANE_W (LANE_W),
        .WIDX_W (WIDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .aw_addr  (aw_addr),
        .aw_len   (aw_len),
        .aw_size  (aw_size),
        .aw_burst (aw_burst),
        .aw_valid (aw_valid),
        .aw_ready (aw_ready),
        .w_valid  (w_valid),
        .w_last   (w_last),
        .w_ready  (w_ready),
        .b_resp   (b_resp),
        .b_valid  (b_valid),
        .b_ready  (b_ready),
        .nxt_addr (nxt_addr),
        .cur_addr (cur_addr),
        .cur_size (cur_size),
        .wr_word  (wr_word),
        .wr_en    (wr_en)
    );

    wr_burst_step #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .cur_addr (cur_addr),
        .size     (cur_size),
        .nxt_addr (nxt_addr)
    );

    wr_burst_mem #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .wr_word (wr_word),
        .wr_data (w_data),
        .wr_strb (w_strb),
        .rd_word (mem_rd_word),
        .rd_data (mem_rd_data)
    );
endmodule

// File: rtl/wr_burst_chk.sv
module wr_burst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       aw_valid,
    input logic       aw_ready,
    input logic       w_valid,
    input logic       w_ready,
    input logic       w_last,
    input logic [1:0] b_resp,
    input logic       b_valid,
    input logic       b_ready
);
    // R9: address channel closes right after its handshake
    a_r9_aw_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> !aw_ready);

    // R2: data channel opens on the cycle after the address handshake
    a_r2_w_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> w_ready);

    // R2: data ready never overlaps address ready or a pending response
    a_r2_w_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        w_ready |-> (!aw_ready && !b_valid));

    // R5: response follows the last accepted beat
    a_r5_b_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && w_last) |=> b_valid);

    // R5: response held steady until taken
    a_r5_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));

    // R6: only OKAY or SLVERR codes appear
    a_r6_resp_code: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_resp == 2'b00 || b_resp == 2'b10));

    // R9: address channel reopens after the response handshake
    a_r9_aw_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |=> aw_ready);
endmodule

bind wr_burst_target wr_burst_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_last   (w_last),
    .b_resp   (b_resp),
    .b_valid  (b_valid),
    .b_ready  (b_ready)
);

// File: tb/wr_burst_target_tb.sv
module wr_burst_target_tb_top;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] len;
        logic [2:0] size;
        logic [1:0] burst;
        logic [7:0] last_at;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'd0, 3'd2, 2'd1, 8'd0},   // single beat, R6
        '{8'h10, 8'd3, 3'd2, 2'd1, 8'd3},   // aligned word burst
        '{8'h01, 8'd4, 3'd2, 2'd1, 8'd4},   // unaligned word burst, R4
        '{8'h23, 8'd4, 3'd1, 2'd1, 8'd4},   // unaligned halfword, R4
        '{8'h30, 8'd5, 3'd0, 2'd1, 8'd5},   // byte beats, R3
        '{8'h08, 8'd3, 3'd2, 2'd1, 8'd1},   // early last, R7
        '{8'h18, 8'd1, 3'd2, 2'd1, 8'd3},   // late last, R8
        '{8'h04, 8'd2, 3'd2, 2'd0, 8'd2},   // fixed type, R10
        '{8'h3C, 8'd2, 3'd2, 2'd1, 8'd2},   // memory wrap, R4
        '{8'h20, 8'd1, 3'd3, 2'd1, 8'd1}    // oversize, R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  aw_addr = '0;
    logic [7:0]  aw_len = '0;
    logic [2:0]  aw_size = '0;
    logic [1:0]  aw_burst = '0;
    logic        aw_valid = 1'b0;
    logic        aw_ready;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        w_last = 1'b0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic [1:0]  b_resp;
    logic        b_valid;
    logic        b_ready = 1'b0;
    logic [3:0]  mem_rd_word = '0;
    logic [31:0] mem_rd_data;

    logic [7:0]  model [64];
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    wr_burst_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .aw_addr     (aw_addr),
        .aw_len      (aw_len),
        .aw_size     (aw_size),
        .aw_burst    (aw_burst),
        .aw_valid    (aw_valid),
        .aw_ready    (aw_ready),
        .w_data      (w_data),
        .w_strb      (w_strb),
        .w_last      (w_last),
        .w_valid     (w_valid),
        .w_ready     (w_ready),
        .b_resp      (b_resp),
        .b_valid     (b_valid),
        .b_ready     (b_ready),
        .mem_rd_word (mem_rd_word),
        .mem_rd_data (mem_rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic compare_mem(input string req);
        for (int w = 0; w < 16; w++) begin
            logic [31:0] exp;
            mem_rd_word = 4'(w);
            #1;
            exp = {model[w*4+3], model[w*4+2], model[w*4+1], model[w*4]};
            chk(mem_rd_data == exp, req, mem_rd_data, exp);
        end
    endtask

    task automatic run_burst(input vec_t v);
        logic [7:0] cur;
        logic [7:0] step;
        logic [7:0] al;
        logic [1:0] exp_resp;
        int         nb;
        bit         bad;
        string      tag;
        cur      = v.addr;
        nb       = int'(v.last_at) + 1;
        bad      = (v.burst != 2'b01) || (v.size > 3'd2);
        exp_resp = (bad || v.last_at != v.len) ? 2'b10 : 2'b00;
        tag      = bad ? "R10" : (v.last_at < v.len) ? "R7" : (v.last_at > v.len) ? "R8" : "R6";

        repeat ($urandom % 3) @(negedge clk);
        chk(!w_ready && aw_ready, "R2 idle before address", {30'd0, w_ready, aw_ready}, 32'd1);
        aw_addr  = v.addr;
        aw_len   = v.len;
        aw_size  = v.size;
        aw_burst = v.burst;
        aw_valid = 1'b1;
        while (!aw_ready) @(negedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
        chk(w_ready && !aw_ready, "R9 address closed, R2 data open", {30'd0, w_ready, aw_ready}, 32'd2);

        for (int b = 0; b < nb; b++) begin
            logic [31:0] d;
            logic [3:0]  s;
            repeat ($urandom % 3) @(negedge clk);
            step = 8'd1 << v.size;
            al   = cur & ~(step - 8'd1);
            d    = $urandom;
            s    = '0;
            for (int l = 0; l < 4; l++) begin
                if (v.size > 3'd2) s[l] = 1'b1;
                else if (l >= int'(cur[1:0]) && l < int'(al[1:0]) + int'(step)) s[l] = 1'b1;
            end
            w_data  = d;
            w_strb  = s;
            w_last  = (b == nb - 1);
            w_valid = 1'b1;
            chk(!b_valid, "R5 no early response", {31'd0, b_valid}, 32'd0);
            while (!w_ready) @(negedge clk);
            @(negedge clk);
            w_valid = 1'b0;
            w_last  = 1'b0;
            if (!bad && b <= int'(v.len)) begin
                for (int l = 0; l < 4; l++)
                    if (s[l]) model[int'(cur[5:2]) * 4 + l] = d[8*l +: 8];
            end
            cur = al + step;
        end

        chk(b_valid && b_resp == exp_resp, tag, {29'd0, b_valid, b_resp}, {29'd1, exp_resp});
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk(b_valid && b_resp == exp_resp, "R5 response held", {29'd0, b_valid, b_resp}, {29'd1, exp_resp});
        end
        b_ready = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
        chk(!b_valid && aw_ready, "R9 reopen after response", {30'd0, b_valid, aw_ready}, 32'd1);
        compare_mem("R3 R4 memory contents");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(aw_ready && !w_ready && !b_valid, "R1 reset outputs",
            {29'd0, aw_ready, w_ready, b_valid}, 32'd4);
        compare_mem("R1 memory cleared");

        // R2: data offered while idle is ignored
        w_data  = 32'hDEADBEEF;
        w_strb  = 4'hF;
        w_last  = 1'b1;
        w_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(!b_valid && !w_ready && aw_ready, "R2 idle data ignored",
            {29'd0, b_valid, w_ready, aw_ready}, 32'd1);
        w_valid = 1'b0;
        w_last  = 1'b0;
        compare_mem("R2 idle data no write");

        for (int k = 0; k < NVEC; k++) run_burst(VECS[k]);

        // Repeat the table with different stall patterns
        for (int k = 0; k < NVEC; k++) run_burst(VECS[k]);

        // R8: long overrun from a single-beat count
        run_burst('{8'h2C, 8'd0, 3'd2, 2'd1, 8'd4});
        // R7: last flag on the first beat of a long count
        run_burst('{8'h14, 8'd7, 3'd2, 2'd1, 8'd0});

        finish_run();
    end
endmodule